// File: doc/BRIEF.md
# Message-Signalled Interrupt Receive Bank

This block receives message-signalled interrupts as plain register writes. A device raises an interrupt by writing a data word to a single index register. The block decodes that word into a register-select field and a bit-select field, then sets the chosen bit in one of a small set of shared 32-bit pending registers. Each pending register drives its own interrupt line, which stays high while any bit in it is set.

Software handles an interrupt line by reading the matching pending register. The read returns every pending source of that register at once and clears them, so no separate acknowledge write is needed. Parameters choose between two index-word field layouts and two register maps (a wide one and a narrow one). An optional compatibility mode reverses the byte order of the written word before it is decoded.

The bus side has independent write and read ports, so a new message and a clearing read of the same register can arrive in the same cycle. Access decoding classifies each access as none, index, pending register or unmapped.

Top module: `msgirq_bank`

## Requirements
- R1: With ALT_LAYOUT=0 the index word bits [4:0] give the bit number and bits [8:5] give the register number; other bits are ignored.
- R2: With ALT_LAYOUT=1 the index word bits [3:0] give the register number and bits [8:4] give the bit number; other bits are ignored.
- R3: With NARROW_MAP=0 pending register k sits at byte address 0x10*k and the index register at 0x140; with NARROW_MAP=1 pending register k sits at 4*k and the index register at 0x38.
- R4: A write to the index register sets exactly the selected bit of the selected pending register; bits already pending stay set.
- R5: A read of pending register k returns its contents on rd_data in the cycle after rd_en and clears the register; rd_data holds its value while rd_en is low.
- R6: irq[k] is high exactly while pending register k is nonzero.
- R7: With SWAP_BYTES=1 the written word is byte-reversed (byte 0 exchanged with byte 3, byte 1 with byte 2) before decoding.
- R8: When an index write sets a bit in register k in the same cycle that a read clears register k, the read returns the old contents and the newly set bit remains pending.
- R9: An index word whose register number is NUM_REGS or more sets no bit and raises no interrupt.
- R10: Reads of the index register or of unmapped addresses return zero; writes to pending registers or unmapped addresses change nothing.
- R11: Synchronous active-high reset clears all pending registers, all interrupt lines and rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | NUM_REGS | One interrupt line per pending register |

## Verification
The hardest case to reach is a new message landing in a register in the very cycle software reads and clears that register; a single shared bus can never produce it. The bench drives the write port and the read port in the same cycle against one register, then reads it twice to show the old value came back first and the new bit survived. It also sweeps every register-select value from 0 to 15 against every bit number in both layouts and both maps, so out-of-range selects are hit alongside valid ones.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;

    localparam int SRC_PER_REG = 32;
    localparam int BIT_W       = 5;
    localparam int SEL_W       = 4;

    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_INDEX    = 2'd1,
        ACC_STATUS   = 2'd2,
        ACC_UNMAPPED = 2'd3
    } acc_kind_t;

    function automatic int reg_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [31:0] swap32(logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/msgirq_addr_dec.sv
module msgirq_addr_dec
    import msgirq_pkg::*;
#(
    parameter int NUM_REGS   = 8,
    parameter int ADDR_W     = 12,
    parameter bit NARROW_MAP = 1'b0,
    parameter int REG_W      = reg_w(NUM_REGS)
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind,
    output logic [REG_W-1:0]  reg_idx
);
    // R3: register map choice
    localparam int STRIDE = NARROW_MAP ? 4 : 16;
    localparam logic [ADDR_W-1:0] IDX_OFF = NARROW_MAP ? ADDR_W'(12'h038) : ADDR_W'(12'h140);

    always_comb begin
        kind    = ACC_NONE;
        reg_idx = '0;
        if (en) begin
            kind = ACC_UNMAPPED;
            if (addr == IDX_OFF) begin
                kind = ACC_INDEX;
            end
            for (int i = 0; i < NUM_REGS; i++) begin
                if (addr == ADDR_W'(i * STRIDE)) begin
                    kind    = ACC_STATUS;
                    reg_idx = REG_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/msgirq_index_dec.sv
module msgirq_index_dec
    import msgirq_pkg::*;
#(
    parameter int NUM_REGS   = 8,
    parameter bit ALT_LAYOUT = 1'b0,
    parameter bit SWAP_BYTES = 1'b0,
    parameter int REG_W      = reg_w(NUM_REGS)
) (
    input  logic             valid,
    input  logic [31:0]      data,
    output logic             hit,
    output logic [REG_W-1:0] reg_idx,
    output logic [BIT_W-1:0] bit_idx
);
    logic [31:0]      word;
    logic [SEL_W-1:0] sel;
    logic             unused_hi;

    // R7: optional byte reversal ahead of decoding
    generate
        if (SWAP_BYTES) begin : g_swap
            assign word = swap32(data);
        end else begin : g_plain
            assign word = data;
        end
    endgenerate

    // R1 / R2: field layout
    generate
        if (ALT_LAYOUT) begin : g_alt
            assign sel     = word[SEL_W-1:0];
            assign bit_idx = word[SEL_W +: BIT_W];
        end else begin : g_std
            assign bit_idx = word[BIT_W-1:0];
            assign sel     = word[BIT_W +: SEL_W];
        end
    endgenerate

    assign unused_hi = ^word[31:BIT_W+SEL_W];

    // R9: selects past the implemented registers are dropped
    assign hit     = valid && (int'(sel) < NUM_REGS);
    assign reg_idx = REG_W'(sel);

endmodule

// File: rtl/msgirq_status_bank.sv
module msgirq_status_bank
    import msgirq_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = reg_w(NUM_REGS)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   set_en,
    input  logic [REG_W-1:0]                       set_reg,
    input  logic [BIT_W-1:0]                       set_bit,
    input  logic                                   clr_en,
    input  logic [REG_W-1:0]                       clr_reg,
    output logic [NUM_REGS-1:0][SRC_PER_REG-1:0]   status,
    output logic [NUM_REGS-1:0]                    irq
);
    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
            logic [SRC_PER_REG-1:0] set_mask;
            logic                   clr_here;

            assign set_mask = (set_en && set_reg == REG_W'(k))
                              ? (SRC_PER_REG'(1) << set_bit) : '0;
            assign clr_here = clr_en && clr_reg == REG_W'(k);

            // R8: set is merged after the clear, so a new bit survives
            always_ff @(posedge clk) begin
                if (rst) begin
                    status[k] <= '0;
                end else begin
                    status[k] <= (clr_here ? '0 : status[k]) | set_mask;
                end
            end

            // R6: line follows register occupancy
            assign irq[k] = |status[k];
        end
    endgenerate

endmodule

// File: rtl/msgirq_bank.sv
module msgirq_bank
    import msgirq_pkg::*;
#(
    parameter int NUM_REGS   = 8,
    parameter int ADDR_W     = 12,
    parameter bit NARROW_MAP = 1'b0,
    parameter bit ALT_LAYOUT = 1'b0,
    parameter bit SWAP_BYTES = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [31:0]         rd_data,
    output logic [NUM_REGS-1:0] irq
);
    localparam int REG_W = reg_w(NUM_REGS);

    acc_kind_t        wr_kind;
    acc_kind_t        rd_kind;
    logic [REG_W-1:0] wr_reg_unused;
    logic [REG_W-1:0] rd_reg;
    logic             idx_hit;
    logic [REG_W-1:0] idx_reg;
    logic [BIT_W-1:0] idx_bit;
    logic             clr_en;
    logic [NUM_REGS-1:0][SRC_PER_REG-1:0] status;

    msgirq_addr_dec #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .NARROW_MAP(NARROW_MAP), .REG_W(REG_W)
    ) u_wr_dec (
        .en(wr_en), .addr(wr_addr), .kind(wr_kind), .reg_idx(wr_reg_unused)
    );

    msgirq_addr_dec #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .NARROW_MAP(NARROW_MAP), .REG_W(REG_W)
    ) u_rd_dec (
        .en(rd_en), .addr(rd_addr), .kind(rd_kind), .reg_idx(rd_reg)
    );

    // R10: only the index register accepts writes
    msgirq_index_dec #(
        .NUM_REGS(NUM_REGS), .ALT_LAYOUT(ALT_LAYOUT), .SWAP_BYTES(SWAP_BYTES), .REG_W(REG_W)
    ) u_idx_dec (
        .valid(wr_kind == ACC_INDEX), .data(wr_data),
        .hit(idx_hit), .reg_idx(idx_reg), .bit_idx(idx_bit)
    );

    assign clr_en = (rd_kind == ACC_STATUS);

    msgirq_status_bank #(
        .NUM_REGS(NUM_REGS), .REG_W(REG_W)
    ) u_bank (
        .clk(clk), .rst(rst),
        .set_en(idx_hit), .set_reg(idx_reg), .set_bit(idx_bit),
        .clr_en(clr_en), .clr_reg(rd_reg),
        .status(status), .irq(irq)
    );

    // R5 / R10: registered read path
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (rd_kind)
                ACC_STATUS:   rd_data <= status[rd_reg];
                ACC_INDEX:    rd_data <= '0;
                ACC_UNMAPPED: rd_data <= '0;
                ACC_NONE:     rd_data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/msgirq_bank_chk.sv
module msgirq_bank_chk #(
    parameter int NUM_REGS   = 8,
    parameter int ADDR_W     = 12,
    parameter bit NARROW_MAP = 1'b0,
    parameter int REG_W      = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [31:0]         rd_data,
    input logic [NUM_REGS-1:0] irq,
    input logic                set_hit,
    input logic [REG_W-1:0]    set_reg
);
    localparam int STRIDE = NARROW_MAP ? 4 : 16;
    localparam logic [ADDR_W-1:0] IDX_OFF = NARROW_MAP ? ADDR_W'(12'h038) : ADDR_W'(12'h140);

    a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == '0 && irq == '0));

    a_r5_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    a_r4_rise_needs_index_write: assert property (@(posedge clk) disable iff (rst)
        (|(irq & ~$past(irq))) |-> ($past(wr_en) && $past(wr_addr) == IDX_OFF));

    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_k
            localparam logic [ADDR_W-1:0] ST = ADDR_W'(k * STRIDE);

            a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
                (rd_en && rd_addr == ST && !(set_hit && set_reg == REG_W'(k))) |=> !irq[k]);

            a_r8_set_survives: assert property (@(posedge clk) disable iff (rst)
                (set_hit && set_reg == REG_W'(k)) |=> irq[k]);

            a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == ST && !(rd_en && rd_addr == ST)) |=> $stable(irq[k]));
        end
    endgenerate

endmodule

bind msgirq_bank msgirq_bank_chk #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .NARROW_MAP(NARROW_MAP), .REG_W(REG_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .set_hit(idx_hit), .set_reg(idx_reg)
);

// File: tb/msgirq_bank_tb.sv
module msgirq_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic        wr_en   [2];
    logic        rd_en   [2];
    logic [11:0] wr_addr [2];
    logic [11:0] rd_addr [2];
    logic [31:0] wr_data [2];
    logic [31:0] rd_data [2];
    logic [NREG-1:0] irq [2];

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // wide map, standard layout, no swap
    msgirq_bank #(.NUM_REGS(NREG), .ADDR_W(12), .NARROW_MAP(1'b0), .ALT_LAYOUT(1'b0), .SWAP_BYTES(1'b0)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en[0]), .wr_addr(wr_addr[0]), .wr_data(wr_data[0]),
        .rd_en(rd_en[0]), .rd_addr(rd_addr[0]), .rd_data(rd_data[0]), .irq(irq[0]));

    // narrow map, alternate layout, byte swap
    msgirq_bank #(.NUM_REGS(NREG), .ADDR_W(12), .NARROW_MAP(1'b1), .ALT_LAYOUT(1'b1), .SWAP_BYTES(1'b1)) u_alt (
        .clk(clk), .rst(rst), .wr_en(wr_en[1]), .wr_addr(wr_addr[1]), .wr_data(wr_data[1]),
        .rd_en(rd_en[1]), .rd_addr(rd_addr[1]), .rd_data(rd_data[1]), .irq(irq[1]));

    function automatic logic [31:0] enc(int w, int sel, int b);
        logic [31:0] x;
        if (w == 0) begin
            x = 32'(b) | (32'(sel) << 5);
        end else begin
            x = (32'(b) << 4) | 32'(sel);
            x = {x[7:0], x[15:8], x[23:16], x[31:24]};
        end
        return x;
    endfunction

    function automatic logic [11:0] st_addr(int w, int k);
        return (w == 0) ? 12'(k * 16) : 12'(k * 4);
    endfunction

    function automatic logic [11:0] idx_addr(int w);
        return (w == 0) ? 12'h140 : 12'h038;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(int w, bit we, logic [11:0] wa, logic [31:0] wd,
                       bit re, logic [11:0] ra, output logic [31:0] q);
        wr_en[w] = we; wr_addr[w] = wa; wr_data[w] = wd;
        rd_en[w] = re; rd_addr[w] = ra;
        @(negedge clk);
        wr_en[w] = 1'b0; rd_en[w] = 1'b0;
        q = rd_data[w];
    endtask

    task automatic wr(int w, logic [11:0] a, logic [31:0] d);
        logic [31:0] q;
        bus(w, 1'b1, a, d, 1'b0, 12'h0, q);
    endtask

    task automatic rd(int w, logic [11:0] a, output logic [31:0] q);
        bus(w, 1'b0, 12'h0, 32'h0, 1'b1, a, q);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] q;
        for (int w = 0; w < 2; w++) begin
            wr_en[w] = 0; rd_en[w] = 0; wr_addr[w] = 0; rd_addr[w] = 0; wr_data[w] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        for (int w = 0; w < 2; w++) begin
            chk("R11 irq after reset", 32'(irq[w]), 32'h0);
            chk("R11 rd_data after reset", rd_data[w], 32'h0);
        end

        // R1 R2 R3 R7 R9 R5 R6: full sweep of select and bit values
        for (int w = 0; w < 2; w++) begin
            for (int sel = 0; sel < 16; sel++) begin
                for (int b = 0; b < 32; b++) begin
                    wr(w, idx_addr(w), enc(w, sel, b));
                    if (sel < NREG) begin
                        chk(w == 0 ? "R6 R1 irq after set" : "R6 R2 R7 irq after set",
                            32'(irq[w]), 32'h1 << sel);
                        rd(w, st_addr(w, sel), q);
                        chk(w == 0 ? "R1 R3 read value" : "R2 R3 R7 read value",
                            q, 32'h1 << b);
                        chk("R5 irq cleared by read", 32'(irq[w]), 32'h0);
                    end else begin
                        chk("R9 out of range select ignored", 32'(irq[w]), 32'h0);
                    end
                end
            end
        end

        // R4: accumulation across writes, R6 per-line
        wr(0, 12'h140, enc(0, 2, 3));
        wr(0, 12'h140, enc(0, 2, 7));
        wr(0, 12'h140, enc(0, 2, 31));
        wr(0, 12'h140, enc(0, 5, 0));
        wr(0, 12'h140, 32'hFFFF_FE00 | enc(0, 5, 0));
        chk("R6 two lines high", 32'(irq[0]), 32'h24);
        rd(0, 12'h020, q);
        chk("R4 accumulated bits", q, 32'h8000_0088);
        chk("R6 line 2 drops line 5 stays", 32'(irq[0]), 32'h20);
        repeat (3) @(negedge clk);
        chk("R5 rd_data holds while idle", rd_data[0], 32'h8000_0088);
        rd(0, 12'h020, q);
        chk("R5 second read empty", q, 32'h0);

        // R10: writes to status and unmapped addresses ignored; unmapped reads zero
        wr(0, 12'h050, 32'hFFFF_FFFF);
        wr(0, 12'h0F0, enc(0, 1, 4));
        chk("R10 stray writes leave lines", 32'(irq[0]), 32'h20);
        rd(0, 12'h050, q);
        chk("R10 status write had no effect", q, 32'h1);
        rd(0, 12'h004, q);
        chk("R10 unmapped read zero", q, 32'h0);
        rd(0, 12'h140, q);
        chk("R10 index read zero", q, 32'h0);
        rd(1, 12'h020, q);
        chk("R10 narrow map unmapped read zero", q, 32'h0);
        wr(1, 12'h010, 32'hFFFF_FFFF);
        chk("R10 narrow status write ignored", 32'(irq[1]), 32'h0);

        // R8: same-cycle set and clearing read
        for (int w = 0; w < 2; w++) begin
            wr(w, idx_addr(w), enc(w, 4, 1));
            bus(w, 1'b1, idx_addr(w), enc(w, 4, 9), 1'b1, st_addr(w, 4), q);
            chk("R8 read returns old contents", q, 32'h2);
            chk("R8 line stays high", 32'(irq[w]), 32'h10);
            rd(w, st_addr(w, 4), q);
            chk("R8 new bit survived", q, 32'h200);
        end

        // R11: reset mid-run
        wr(0, 12'h140, enc(0, 3, 12));
        rd(1, 12'h000, q);
        wr(1, 12'h038, enc(1, 0, 6));
        rd(0, 12'h000, q);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 reset drops lines", 32'(irq[0]), 32'h0);
        chk("R11 reset drops lines alt", 32'(irq[1]), 32'h0);
        chk("R11 reset clears rd_data", rd_data[0], 32'h0);
        rd(0, 12'h030, q);
        chk("R11 register empty after reset", q, 32'h0);

        done = 1;
        finish_run();
    end

endmodule